// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block takes a wide signed fixed-point word and produces a narrower signed fixed-point word. The input format and the output format are both set by parameters: a total bit count and a count of integer bits, the sign bit included. The binary points are aligned by an arithmetic shift. The fraction bits that do not fit in the output are removed by one of three quantization policies. A result that then falls outside the output range is handled by one of three overflow policies. Both policies are chosen at run time, one conversion at a time.

A conversion is started by a one-cycle `in_valid` pulse. The result is registered and appears one clock later, together with `out_valid` and two flags. `out_ovf` reports that the overflow policy changed the value. `out_inexact` reports that nonzero fraction bits were removed. The block accepts a new word every clock.

Top module: `fxq_requant`

## Requirements
- R1: With the default formats (input 16 bits with 4 integer bits, output 8 bits with 1 integer bit), the output LSB equals 32 input LSBs. An input whose 5 low bits are zero and whose value is in range appears unchanged in value, with both flags low.
- R2: With quant_mode 2'b00 (round), a removed fraction of one half output LSB or more adds one output LSB, so halves go toward positive infinity. For example, raw input 16 gives 1 and raw input -16 gives 0.
- R3: With quant_mode 2'b01 (round toward zero), the result is the nearest value and an exact half goes toward zero. For example, raw input 16 gives 0, -16 gives 0 and -48 gives -1.
- R4: With quant_mode 2'b10 (truncate), and with the reserved code 2'b11, the removed bits are dropped. The result is the floor, so raw input -1 gives -1.
- R5: With ovf_mode 2'b00 (saturate), a result above 127 output LSBs becomes 127 and a result below -128 becomes -128.
- R6: With ovf_mode 2'b01 (saturate to zero), any out-of-range result becomes exactly 0.
- R7: With ovf_mode 2'b10 (wrap), and with the reserved code 2'b11, only the low 8 bits of the result are kept, which is two's complement wraparound.
- R8: Quantization happens before the range check. A value that rounds past the maximum is handled by the overflow policy. For example, raw input 4080 in round mode with saturate gives 127 with both flags set.
- R9: out_ovf is 1 exactly when the quantized value lies outside [-128, 127], in every overflow mode.
- R10: out_inexact is 1 exactly when the removed input bits are nonzero, in every mode.
- R11: out_valid equals in_valid delayed by one clock. When in_valid is low, out_data and both flags hold their previous values.
- R12: An asynchronous active-low reset clears out_valid, out_data, out_ovf and out_inexact to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | IN_W | Signed input, IN_I integer bits |
| quant_mode | input | 2 | 00 round, 01 round toward zero, 10/11 truncate |
| ovf_mode | input | 2 | 00 saturate, 01 saturate to zero, 10/11 wrap |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | OUT_W | Signed result, OUT_I integer bits |
| out_ovf | output | 1 | Overflow policy changed the value |
| out_inexact | output | 1 | Nonzero fraction bits were removed |

## Verification
The assertions check these properties on every cycle:
- the one-cycle valid latency and the holding of the result between valid words;
- that a saturated result is one of the two range limits;
- that a zeroed result is zero;
- that an exact conversion with no overflow, or an exact conversion in wrap mode, equals the aligned input bits.

The exact rounding decisions need a reference model of every mode pair, so only the bench's scenarios can show them. These are the tie cases on both signs, rounding past the maximum, and the flag values. The bench also sweeps the input range under all mode pairs.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
  typedef enum logic [1:0] {
    Q_ROUND = 2'b00,
    Q_RTZ   = 2'b01,
    Q_TRUNC = 2'b10,
    Q_RSVD  = 2'b11
  } qmode_e;

  typedef enum logic [1:0] {
    O_SAT   = 2'b00,
    O_ZERO  = 2'b01,
    O_WRAP  = 2'b10,
    O_RSVD  = 2'b11
  } omode_e;
endpackage

// File: rtl/fxq_round.sv
module fxq_round
  import fxq_pkg::*;
#(
  parameter int IN_W = 16,
  parameter int DROP = 5,
  localparam int QW  = IN_W - DROP + 1
) (
  input  logic [IN_W-1:0] in_data,
  input  qmode_e          qmode,
  output logic [QW-1:0]   q_val,
  output logic            inexact
);
  localparam int HW = IN_W - DROP;

  generate
    if (DROP > 0) begin : g_drop
      logic [DROP-1:0] frac;
      logic [DROP-1:0] below_half;
      logic [HW-1:0]   hi;
      logic            half, rest, neg, inc;

      assign frac       = in_data[DROP-1:0];
      assign hi         = in_data[IN_W-1:DROP];
      assign below_half = frac << 1;
      assign half       = frac[DROP-1];
      assign rest       = |below_half;
      assign neg        = in_data[IN_W-1];

      always_comb begin
        case (qmode)
          Q_ROUND: inc = half;
          Q_RTZ:   inc = half & (rest | neg);
          default: inc = 1'b0;
        endcase
      end

      assign q_val   = {hi[HW-1], hi} + {{HW{1'b0}}, inc};
      assign inexact = |frac;
    end else begin : g_nodrop
      logic unused_mode;
      assign unused_mode = ^qmode;
      assign q_val   = {in_data[IN_W-1], in_data};
      assign inexact = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fxq_limit.sv
module fxq_limit
  import fxq_pkg::*;
#(
  parameter int QW    = 12,
  parameter int OUT_W = 8
) (
  input  logic [QW-1:0]    q_val,
  input  omode_e           omode,
  output logic [OUT_W-1:0] res,
  output logic             ovf
);
  localparam int TOPW = QW - OUT_W + 1;
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic [TOPW-1:0] top;
  logic            in_range;

  assign top      = q_val[QW-1:OUT_W-1];
  assign in_range = (&top) | ~(|top);
  assign ovf      = ~in_range;

  always_comb begin
    res = q_val[OUT_W-1:0];
    if (!in_range) begin
      case (omode)
        O_SAT:   res = q_val[QW-1] ? MINV : MAXV;
        O_ZERO:  res = '0;
        default: res = q_val[OUT_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/fxq_requant.sv
module fxq_requant
  import fxq_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int IN_I  = 4,
  parameter int OUT_W = 8,
  parameter int OUT_I = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [1:0]       quant_mode,
  input  logic [1:0]       ovf_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_ovf,
  output logic             out_inexact
);
  localparam int IN_F  = IN_W - IN_I;
  localparam int OUT_F = OUT_W - OUT_I;
  localparam int DROP  = IN_F - OUT_F;
  localparam int QW    = IN_W - DROP + 1;
  localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

  logic [QW-1:0]    q_val;
  logic             q_inexact;
  logic [OUT_W-1:0] lim_res;
  logic             lim_ovf;

  logic             valid_d;
  logic [OUT_W-1:0] data_d;
  logic             ovf_d, inexact_d;

  fxq_round #(.IN_W(IN_W), .DROP(DROP)) u_round (
    .in_data (in_data),
    .qmode   (qmode_e'(quant_mode)),
    .q_val   (q_val),
    .inexact (q_inexact)
  );

  fxq_limit #(.QW(QW), .OUT_W(OUT_W)) u_limit (
    .q_val (q_val),
    .omode (omode_e'(ovf_mode)),
    .res   (lim_res),
    .ovf   (lim_ovf)
  );

  always_comb begin
    valid_d   = in_valid;
    data_d    = out_data;
    ovf_d     = out_ovf;
    inexact_d = out_inexact;
    if (in_valid) begin
      data_d    = lim_res;
      ovf_d     = lim_ovf;
      inexact_d = q_inexact;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_ovf     <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_data    <= data_d;
      out_ovf     <= ovf_d;
      out_inexact <= inexact_d;
    end
  end

  p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_data) && $stable(out_ovf) && $stable(out_inexact)));

  p_sat_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf && $past(ovf_mode) == 2'b00) |->
      (out_data == MAXV || out_data == MINV));

  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf && $past(ovf_mode) == 2'b01) |-> (out_data == '0));

  p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ovf && !out_inexact) |->
      (out_data == $past(in_data[OUT_W+DROP-1:DROP])));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_inexact && $past(ovf_mode[1])) |->
      (out_data == $past(in_data[OUT_W+DROP-1:DROP])));
endmodule

// File: tb/fxq_requant_bench.sv
module fxq_requant_bench;
  localparam int SH = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [15:0] in_data;
  logic [1:0] quant_mode, ovf_mode;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ovf, out_inexact;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fxq_requant u_fxq_requant (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .quant_mode(quant_mode), .ovf_mode(ovf_mode), .out_valid(out_valid),
    .out_data(out_data), .out_ovf(out_ovf), .out_inexact(out_inexact)
  );

  function automatic logic [9:0] model(int x, int qm, int om);
    int hi, f, q;
    bit inc, ovf;
    hi = x >>> SH;
    f  = x & 31;
    case (qm)
      0:       inc = (f >= 16);
      1:       inc = (f > 16) || (f == 16 && x < 0);
      default: inc = 1'b0;
    endcase
    q   = hi + int'(inc);
    ovf = (q > 127) || (q < -128);
    if (ovf) begin
      if (om == 0)      q = (q > 0) ? 127 : -128;
      else if (om == 1) q = 0;
    end
    return {ovf, (f != 0), q[7:0]};
  endfunction

  task automatic check(string req, logic [10:0] act, logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual {valid,ovf,inexact,data}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(int x, int qm, int om, string req);
    @(negedge clk);
    in_valid   = 1'b1;
    in_data    = x[15:0];
    quant_mode = qm[1:0];
    ovf_mode   = om[1:0];
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_ovf, out_inexact, out_data}, {1'b1, model(x, qm, om)});
  endtask

  task automatic t_reset;
    check("R12 reset", {out_valid, out_ovf, out_inexact, out_data}, 11'd0);
  endtask

  task automatic t_exact;
    apply(32 * 37, 0, 0, "R1");
    check("R1 value", {3'b100, out_data}, {3'b100, 8'd37});
    apply(-32 * 100, 1, 2, "R1");
  endtask

  task automatic t_round;
    apply(16, 0, 0, "R2");
    check("R2 lit", {3'b0, out_data}, 11'd1);
    apply(-16, 0, 0, "R2");
    check("R2 lit", {3'b0, out_data}, 11'd0);
    apply(15, 0, 0, "R2");
    apply(-48, 0, 0, "R2");
  endtask

  task automatic t_rtz;
    apply(16, 1, 0, "R3");
    check("R3 lit", {3'b0, out_data}, 11'd0);
    apply(-16, 1, 0, "R3");
    check("R3 lit", {3'b0, out_data}, 11'd0);
    apply(-48, 1, 0, "R3");
    check("R3 lit", {3'b0, out_data}, {3'b0, 8'hFF});
    apply(17, 1, 0, "R3");
    apply(-47, 1, 0, "R3");
  endtask

  task automatic t_trunc;
    apply(-1, 2, 0, "R4");
    check("R4 lit", {3'b0, out_data}, {3'b0, 8'hFF});
    apply(31, 2, 0, "R4");
    apply(-1, 3, 0, "R4 reserved");
  endtask

  task automatic t_ovf;
    apply(32767, 2, 0, "R5");
    check("R5 lit", {3'b0, out_data}, {3'b0, 8'h7F});
    apply(-32768, 0, 0, "R5");
    check("R5 lit", {3'b0, out_data}, {3'b0, 8'h80});
    apply(5000, 0, 1, "R6");
    check("R6 lit", {3'b0, out_data}, 11'd0);
    apply(-9000, 1, 1, "R6");
    apply(4096, 2, 2, "R7");
    check("R7 lit", {3'b0, out_data}, {3'b0, 8'h80});
    apply(-4128, 2, 3, "R7 reserved");
    apply(4080, 0, 0, "R8");
    check("R8 lit", {1'b0, out_ovf, out_inexact, out_data}, {3'b011, 8'h7F});
    apply(4080, 1, 0, "R8");
    apply(4080, 0, 2, "R9");
  endtask

  task automatic t_hold;
    logic [10:0] snap;
    apply(777, 0, 0, "R11");
    snap = {1'b0, out_ovf, out_inexact, out_data};
    @(negedge clk);
    in_data = 16'h7FFF;
    quant_mode = 2'b00;
    ovf_mode = 2'b01;
    repeat (3) @(negedge clk);
    check("R11 hold", {out_valid, out_ovf, out_inexact, out_data}, snap);
  endtask

  task automatic t_sweep;
    for (int qm = 0; qm < 4; qm++)
      for (int om = 0; om < 4; om++)
        for (int x = -32768; x < 32768; x += 331)
          apply(x, qm, om, "R9/R10 sweep");
  endtask

  task automatic t_reset_mid;
    apply(32767, 0, 0, "R12 pre");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 async", {out_valid, out_ovf, out_inexact, out_data}, 11'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    quant_mode = '0;
    ovf_mode = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exact();
    t_round();
    t_rtz();
    t_trunc();
    t_ovf();
    t_hold();
    t_sweep();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule